// File: doc/BRIEF.md
# Loopback Interface-Type Detector

This block runs once after reset and decides how the board is wired. A board may tie the block's test output back to one of its port inputs, or it may leave that input unconnected. The block drives a repeating square wave on the test output and watches the input. If the input follows the wave, the board is the loop-wired (PS/2 style) kind. If nothing comes back before a long fallback timeout expires, the block chooses the legacy (AT style) wiring.

The input has an internal pull-up, so an open pin reads high. For that reason a match needs the input to be high in the middle of a high phase and low in the middle of the following low phase. The sequence does not start until the input has been seen high for a programmable settle time. Time is counted from the end of reset or from the release of the input, whichever comes later, so a device that holds the line low at power-up delays detection. When the decision is made, a one-cycle strobe fires and a mode flag is latched. The flag holds until the next reset, and the test output rests at its idle high level. The input is asynchronous and passes through a synchronizer. There is no data stream and no handshake. Every pin is a plain control or status pin.

Top module: `lpbk_mode_detect`

## Requirements
- R1: While `rst_n` is low, `test_out` is 1, `mode_valid` is 0 and `detect_done` is 0.
- R2: `loop_in` passes through `SYNC_STAGES` flops. Pulsing starts only after the synchronized input has been high for `START_DLY` consecutive cycles, and any low sample restarts that count. With the input high from the end of reset, the first fall of `test_out` comes `SYNC_STAGES+START_DLY+PHASE_LEN` rising edges after the release.
- R3: While no decision exists, `test_out` repeats a pattern of `PHASE_LEN` cycles high followed by `PHASE_LEN` cycles low.
- R4: A match happens when the synchronized input is 1 at count `PHASE_LEN/2` of a high phase and 0 at count `PHASE_LEN/2` of the low phase that follows. A match selects `mode_ps2`=1, and `detect_done` rises on the edge after that low-phase sample. In the first low phase this is `SYNC_STAGES+START_DLY+PHASE_LEN+PHASE_LEN/2+1` edges after release.
- R5: If `TIMEOUT` cycles pass from the start of pulsing without a match, `mode_ps2`=0 is selected. `detect_done` fires `SYNC_STAGES+START_DLY+TIMEOUT` edges after release. A match in the same cycle takes priority.
- R6: `detect_done` is high for exactly one cycle, in the cycle where `mode_valid` first goes high.
- R7: After the decision, `mode_ps2` and `mode_valid`=1 hold until reset, `test_out` stays 1, and `loop_in` has no effect.
- R8: If `loop_in` stays low, pulsing never starts and no decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_in | input | 1 | Loopback sense input, asynchronous, pulled high when open |
| test_out | output | 1 | Test wave output, idle high |
| mode_ps2 | output | 1 | 1 = loop-wired (PS/2 style), 0 = legacy (AT style); valid when mode_valid is 1 |
| mode_valid | output | 1 | Decision latched |
| detect_done | output | 1 | One-cycle strobe when the decision is made |

## Verification
The bench builds the block with `START_DLY`=20, `PHASE_LEN`=16, `TIMEOUT`=200 and `SYNC_STAGES`=2. With these values the settle delay, several full pulses and the fallback timeout all fit within a few hundred cycles. Every decision point therefore lands on a cycle number that can be computed exactly: the first edge of the wave, the match sample and the timeout. Delayed input release, a glitch during the settle period, late connection of the loop and a permanently low input all become short runs.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_HIGH   = 2'd1,
    ST_LOW    = 2'd2,
    ST_FINAL  = 2'd3
  } lmd_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/lmd_sync.sv
module lmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= 1'b0;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lmd_timer.sv
module lmd_timer #(
  parameter int LIMIT = 16,
  parameter int MARK  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit,
  output logic mark
);
  localparam int W = lmd_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] MPOS = W'(MARK);

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr)        count <= '0;
    else if (en) begin
      if (count == LAST) count <= '0;
      else               count <= count + 1'b1;
    end
  end

  assign hit  = en && !clr && (count == LAST);
  assign mark = en && !clr && (count == MPOS);
endmodule

// File: rtl/lmd_fsm.sv
module lmd_fsm
  import lmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_s,
  input  logic       settle_hit,
  input  logic       phase_hit,
  input  logic       phase_mid,
  input  logic       timeout_hit,
  output lmd_state_e state,
  output logic       mode_ps2,
  output logic       mode_valid,
  output logic       detect_done
);
  logic high_seen;
  logic match;

  assign match = (state == ST_LOW) && phase_mid && high_seen && !loop_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_SETTLE;
      high_seen   <= 1'b0;
      mode_ps2    <= 1'b0;
      mode_valid  <= 1'b0;
      detect_done <= 1'b0;
    end else begin
      detect_done <= 1'b0;
      unique case (state)
        ST_SETTLE: begin
          high_seen <= 1'b0;
          if (settle_hit) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (phase_mid) high_seen <= loop_s;
          if (timeout_hit) begin
            state       <= ST_FINAL;
            mode_ps2    <= 1'b0;
            mode_valid  <= 1'b1;
            detect_done <= 1'b1;
          end else if (phase_hit) begin
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (match) begin
            state       <= ST_FINAL;
            mode_ps2    <= 1'b1;
            mode_valid  <= 1'b1;
            detect_done <= 1'b1;
          end else if (timeout_hit) begin
            state       <= ST_FINAL;
            mode_ps2    <= 1'b0;
            mode_valid  <= 1'b1;
            detect_done <= 1'b1;
          end else if (phase_hit) begin
            state <= ST_HIGH;
          end
        end
        default: state <= ST_FINAL;
      endcase
    end
  end
endmodule

// File: rtl/lpbk_mode_detect.sv
module lpbk_mode_detect
  import lmd_pkg::*;
#(
  parameter int START_DLY   = 8000,
  parameter int PHASE_LEN   = 1760,
  parameter int TIMEOUT     = 512000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_in,
  output logic test_out,
  output logic mode_ps2,
  output logic mode_valid,
  output logic detect_done
);
  localparam int PHASE_MID = PHASE_LEN / 2;

  lmd_state_e state;
  logic loop_s;
  logic settle_hit, phase_hit, phase_mid, timeout_hit;
  logic unused_settle_mark, unused_timeout_mark;
  logic pulsing;

  assign pulsing = (state == ST_HIGH) || (state == ST_LOW);

  lmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(loop_in), .q(loop_s)
  );

  lmd_timer #(.LIMIT(START_DLY), .MARK(0)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .clr((state != ST_SETTLE) || !loop_s),
    .en(state == ST_SETTLE),
    .hit(settle_hit), .mark(unused_settle_mark)
  );

  lmd_timer #(.LIMIT(PHASE_LEN), .MARK(PHASE_MID)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .clr(!pulsing), .en(1'b1),
    .hit(phase_hit), .mark(phase_mid)
  );

  lmd_timer #(.LIMIT(TIMEOUT), .MARK(0)) u_timeout (
    .clk(clk), .rst_n(rst_n),
    .clr(!pulsing), .en(1'b1),
    .hit(timeout_hit), .mark(unused_timeout_mark)
  );

  lmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .loop_s(loop_s),
    .settle_hit(settle_hit), .phase_hit(phase_hit),
    .phase_mid(phase_mid), .timeout_hit(timeout_hit),
    .state(state), .mode_ps2(mode_ps2),
    .mode_valid(mode_valid), .detect_done(detect_done)
  );

  assign test_out = (state != ST_LOW);
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
  parameter int PHASE_LEN = 1760
) (
  input logic clk,
  input logic rst_n,
  input logic test_out,
  input logic mode_ps2,
  input logic mode_valid,
  input logic detect_done
);
  localparam int RW = $clog2(PHASE_LEN + 2) + 1;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (test_out) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    detect_done |=> !detect_done); // R6
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> detect_done); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> (mode_valid && $stable(mode_ps2))); // R7
  AST_IDLE_AFTER_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> test_out); // R7
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(test_out) && !mode_valid) |-> (low_run == RW'(PHASE_LEN))); // R3
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RW'(PHASE_LEN)); // R3
endmodule

bind lpbk_mode_detect lmd_checker #(.PHASE_LEN(PHASE_LEN)) u_lmd_checker (
  .clk(clk), .rst_n(rst_n), .test_out(test_out),
  .mode_ps2(mode_ps2), .mode_valid(mode_valid), .detect_done(detect_done)
);

// File: tb/test_lpbk_mode_detect.sv
module test_lpbk_mode_detect;
  localparam int CLK_PERIOD = 10;
  localparam int START_DLY  = 20;
  localparam int PHASE_LEN  = 16;
  localparam int TIMEOUT    = 200;
  localparam int SYNC       = 2;
  localparam int MID        = PHASE_LEN / 2;
  localparam int BASE_FALL  = SYNC + START_DLY + PHASE_LEN;
  localparam int BASE_MATCH = SYNC + START_DLY + PHASE_LEN + MID + 1;
  localparam int BASE_TOUT  = SYNC + START_DLY + TIMEOUT;
  localparam int NVEC = 4;
  // vector table: hold-low cycles after release, loop wired, expected mode
  localparam int V_HOLD [NVEC] = '{0, 0, 30, 30};
  localparam bit V_LOOP [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_low = 1'b0;
  logic conn_loop = 1'b0;
  logic loop_in, test_out, mode_ps2, mode_valid, detect_done;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign loop_in = force_low ? 1'b0 : (conn_loop ? test_out : 1'b1);

  lpbk_mode_detect #(.START_DLY(START_DLY), .PHASE_LEN(PHASE_LEN),
                     .TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC)) i_lpbk_mode_detect (
    .clk(clk), .rst_n(rst_n), .loop_in(loop_in), .test_out(test_out),
    .mode_ps2(mode_ps2), .mode_valid(mode_valid), .detect_done(detect_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(test_out == 1'b1, "R1 test_out in reset", int'(test_out), 1);
    check(mode_valid == 1'b0 && detect_done == 1'b0, "R1 flags in reset",
          int'({mode_valid, detect_done}), 0);
  endtask

  // release reset and run until done or limit; glitch_at>=0 pulls input low for one cycle
  task automatic run(input int hold, input int connect_at, input int glitch_at,
                     input int limit, output int fall_at, output int done_at,
                     output bit mode);
    int n = 0;
    fall_at = -1; done_at = -1; mode = 1'b0;
    force_low = (hold > 0);
    rst_n = 1'b1;
    while (n < limit && done_at < 0) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == hold) force_low = 1'b0;
      if (n == connect_at) conn_loop = 1'b1;
      if (n == glitch_at) force_low = 1'b1;
      else if (n == glitch_at + 1) force_low = 1'b0;
      if (!test_out && fall_at < 0) fall_at = n;
      if (detect_done) begin done_at = n; mode = mode_ps2; end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int fa, da, ef, ed;
    bit md;
    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      conn_loop = V_LOOP[v];
      do_reset();
      run(V_HOLD[v], -1, -1, 1000, fa, da, md);
      ef = V_HOLD[v] + BASE_FALL;
      ed = V_HOLD[v] + (V_LOOP[v] ? BASE_MATCH : BASE_TOUT);
      check(fa == ef, "R2 first fall of test_out", fa, ef);
      check(da == ed, V_LOOP[v] ? "R4 match decision cycle" : "R5 timeout decision cycle", da, ed);
      check(md == V_LOOP[v], V_LOOP[v] ? "R4 mode_ps2" : "R5 mode_ps2", int'(md), int'(V_LOOP[v]));
      @(negedge clk);
      check(!detect_done && mode_valid, "R6 single strobe, valid held",
            int'({detect_done, mode_valid}), 1);
      check(test_out == 1'b1, "R7 idle high after decision", int'(test_out), 1);
    end

    // R7: input ignored after a decision
    conn_loop = 1'b1;
    do_reset();
    run(0, -1, -1, 1000, fa, da, md);
    force_low = 1'b1;
    repeat (40) @(negedge clk);
    conn_loop = 1'b0;
    force_low = 1'b0;
    repeat (40) @(negedge clk);
    check(mode_ps2 && mode_valid && test_out, "R7 decision unaffected by input",
          int'({mode_ps2, mode_valid, test_out}), 7);

    // R8: input held low forever
    conn_loop = 1'b0;
    do_reset();
    run(1000000, -1, -1, 600, fa, da, md);
    check(fa == -1, "R8 no pulsing while input low", fa, -1);
    check(da == -1 && !mode_valid, "R8 no decision while input low", da, -1);
    force_low = 1'b0;

    // R2: glitch during settle restarts the count
    conn_loop = 1'b1;
    do_reset();
    run(0, -1, 10, 1000, fa, da, md);
    check(fa == 11 + BASE_FALL, "R2 settle restart after glitch", fa, 11 + BASE_FALL);

    // R4: loop connected late, high phase seen via pull-up, match on third low phase
    conn_loop = 1'b0;
    do_reset();
    run(0, 100, -1, 1000, fa, da, md);
    ed = SYNC + START_DLY + 5 * PHASE_LEN + MID + 1;
    check(da == ed && md, "R4 late loop match", da, ed);

    // R1: reset reasserted mid-pulsing
    conn_loop = 1'b0;
    do_reset();
    run(0, -1, -1, BASE_FALL + 3, fa, da, md);
    check(test_out == 1'b0, "R3 low phase in progress", int'(test_out), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(test_out && !mode_valid, "R1 reset mid-pulse", int'({test_out, mode_valid}), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule